// File: doc/BRIEF.md
# Vectored Edge-Triggered Interrupt Controller

This block collects interrupt requests for a small processor core and presents one of them at a time as a request line plus a 5-bit vector number. Five external pins pass through a two-stage synchroniser, a per-pin function gate and an edge detector whose polarity is chosen per pin. A detected edge sets a sticky flag. Ten internal peripheral strobes set their own sticky flags directly.

Each flag has an enable bit, and one global mask bit blocks every source at once. Among the sources that are pending and enabled, the one with the lowest vector number wins. Its request is registered and held steady until the core acknowledges it. The acknowledge raises the global mask in the same clock edge. Software reaches the flags, enables, pin-function bits, edge selects and mask through a small word-addressed register port. Flags are cleared only by writing 0 to them.

Top module: `vect_intc`

## Requirements
- R1: After reset, irq_req is 0, every flag, enable, pin-function and edge-select bit reads 0, and the mask bit reads 1.
- R2: An external flag bit i is set only when pin-function bit i is 1 and pin i makes the selected transition. Edge-select bit 1 selects a rising edge and 0 selects a falling edge. The flag is readable by the third rising clock edge after the pin changes.
- R3: Writing a 0 to a flag bit clears it, and writing a 1 leaves it unchanged. A set event in the same cycle as a clearing write leaves the flag set.
- R4: A one-cycle internal strobe on int_strobe[j] sets internal flag bit j at the next rising edge.
- R5: A flag whose enable bit is 0 never causes irq_req.
- R6: While the mask bit is 1, irq_req is 0 one cycle later, whatever is pending.
- R7: External pin i maps to vector 4+i. Internal source 0 maps to vector 10 and internal source 1 to vector 11. Internal sources 2 to 9 map to vectors 13 to 20.
- R8: When several enabled sources are pending, the lowest vector number is presented. IRQ0 therefore beats IRQ1, and external sources beat internal ones.
- R9: While irq_req is 1 and irq_ack is 0, irq_vec stays stable. A rising edge with irq_ack at 1 sets the mask bit and drops irq_req.
- R10: irq_req rises one rising edge after an enabled, pending source exists with the mask at 0.
- R11: Register map by reg_addr: 0 holds the external flags (bits 4:0, bit i for pin i), 1 the external enables, 2 the pin-function bits, 3 the edge selects, 4 the internal flags (bits 9:0), 5 the internal enables, and 6 the mask in bit 0. Address 7 reads 0. A write takes effect at the rising edge where reg_we is 1. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 5 | Asynchronous external request pins |
| int_strobe | input | 10 | Internal peripheral request strobes |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 5 | Vector number of the presented request |
| irq_ack | input | 1 | One-cycle acceptance from the core |

## Verification
Each result has a fixed latency. A pin change becomes a flag at the third rising edge, and a strobe or register write lands at the next edge. irq_req and irq_vec follow the flags, enables and mask one edge later, and an acknowledge drops irq_req and raises the mask at the edge where it is sampled. The bench keeps a behavioural model that steps through these same latencies at every rising edge: a queue of past pin samples and a search for the minimum vector in a table. It compares irq_req, irq_vec and the read data at every falling edge. Directed checks wait past these latencies before they read back flags or look at the request pins.

// File: rtl/intc_pkg.sv
// intc_pkg: shared constants, register address codes and the source-to-vector map.
// Assumes sources are numbered external first (pin order), then internal.
package intc_pkg;
    localparam int VEC_W         = 5;
    localparam int EXT_BASE_VEC  = 4;
    localparam int INT_LOW_BASE  = 10;
    localparam int INT_LOW_CNT   = 2;
    localparam int INT_HIGH_BASE = 13;

    typedef enum logic [2:0] {
        RA_EXT_FLAG = 3'd0,
        RA_EXT_EN   = 3'd1,
        RA_PIN_FN   = 3'd2,
        RA_EDGE     = 3'd3,
        RA_INT_FLAG = 3'd4,
        RA_INT_EN   = 3'd5,
        RA_MASK     = 3'd6,
        RA_NONE     = 3'd7
    } reg_addr_e;

    // Vector number of source s; the numbering rises with s, so lower s wins.
    function automatic logic [VEC_W-1:0] src_vector(input int s, input int n_ext);
        int v;
        if (s < n_ext)
            v = EXT_BASE_VEC + s;
        else if ((s - n_ext) < INT_LOW_CNT)
            v = INT_LOW_BASE + (s - n_ext);
        else
            v = INT_HIGH_BASE + (s - n_ext - INT_LOW_CNT);
        return v[VEC_W-1:0];
    endfunction
endpackage

// File: rtl/intc_edge_sync.sv
// intc_edge_sync: per-pin two-flop synchroniser, history flop and
// polarity-selected edge detector, gated by the pin-function bit.
// Assumes the pins are asynchronous and held for at least two clocks.
module intc_edge_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] fn_sel,
    input  logic [W-1:0] edge_rise,
    output logic [W-1:0] edge_hit
);
    logic [W-1:0] sync1, sync2, hist;

    // Capture the pins and shift the synchroniser and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            hist  <= '0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            hist  <= sync2;
        end
    end

    // One detector per pin; polarity and function gate come from registers.
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rose_i, fell_i;
        assign rose_i      = sync2[i] & ~hist[i];
        assign fell_i      = ~sync2[i] & hist[i];
        assign edge_hit[i] = fn_sel[i] & (edge_rise[i] ? rose_i : fell_i);
    end
endmodule

// File: rtl/intc_flag_bank.sv
// intc_flag_bank: sticky request flags. A set input wins over a clearing
// write in the same cycle; writing 1 to a bit leaves it unchanged.
module intc_flag_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_in,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] flags
);
    logic [W-1:0] kept;

    // Bits kept after an optional write-zero-to-clear access.
    always_comb kept = clr_we ? (flags & clr_data) : flags;

    // Update the flags: new set events OR surviving bits.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= kept | set_in;
    end
endmodule

// File: rtl/intc_arbiter.sv
// intc_arbiter: picks the pending source with the lowest vector and
// registers request and vector. A presented request is held until an
// acknowledge or a set mask removes it; an acknowledge also raises the mask
// (done by the parent on the same edge).
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N_EXT = 5,
    parameter int N_INT = 10,
    localparam int N_SRC = N_EXT + N_INT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend,
    input  logic             mask,
    input  logic             ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    logic             any_pend;
    logic [VEC_W-1:0] win_vec;

    // Scan from the highest index down so the lowest pending index remains.
    always_comb begin
        any_pend = |pend;
        win_vec  = '0;
        for (int s = N_SRC - 1; s >= 0; s--) begin
            if (pend[s]) win_vec = src_vector(s, N_EXT);
        end
    end

    // Output stage: drop on ack or mask, load when idle, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
        end else if (ack || mask) begin
            irq_req <= 1'b0;
        end else if (!irq_req && any_pend) begin
            irq_req <= 1'b1;
            irq_vec <= win_vec;
        end
    end
endmodule

// File: rtl/vect_intc.sv
// vect_intc: top level. Holds the software-visible enables, pin-function
// bits, edge selects and global mask, and wires the synchroniser, two flag
// banks and the arbiter. Assumes a single clock and synchronous reset.
module vect_intc
    import intc_pkg::*;
#(
    parameter int N_EXT = 5,
    parameter int N_INT = 10,
    localparam int REG_W = (N_INT > N_EXT) ? N_INT : N_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic [N_INT-1:0] int_strobe,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack
);
    reg_addr_e        addr;
    logic [N_EXT-1:0] ext_en, pin_fn, edge_rise, ext_hit, ext_flags;
    logic [N_INT-1:0] int_en, int_flags;
    logic             mask_q;
    logic             wr_ext_flag, wr_int_flag;

    assign addr        = reg_addr_e'(reg_addr);
    assign wr_ext_flag = reg_we && (addr == RA_EXT_FLAG);
    assign wr_int_flag = reg_we && (addr == RA_INT_FLAG);

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_en    <= '0;
            pin_fn    <= '0;
            edge_rise <= '0;
            int_en    <= '0;
        end else if (reg_we) begin
            case (addr)
                RA_EXT_EN: ext_en    <= reg_wdata[N_EXT-1:0];
                RA_PIN_FN: pin_fn    <= reg_wdata[N_EXT-1:0];
                RA_EDGE:   edge_rise <= reg_wdata[N_EXT-1:0];
                RA_INT_EN: int_en    <= reg_wdata[N_INT-1:0];
                default: ;
            endcase
        end
    end

    // Global mask: set by reset and by an acknowledge, else software-written.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= 1'b1;
        else if (irq_ack)                  mask_q <= 1'b1;
        else if (reg_we && addr == RA_MASK) mask_q <= reg_wdata[0];
    end

    // Combinational read mux, zero-extended to the register width.
    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_EXT_FLAG: reg_rdata[N_EXT-1:0] = ext_flags;
            RA_EXT_EN:   reg_rdata[N_EXT-1:0] = ext_en;
            RA_PIN_FN:   reg_rdata[N_EXT-1:0] = pin_fn;
            RA_EDGE:     reg_rdata[N_EXT-1:0] = edge_rise;
            RA_INT_FLAG: reg_rdata[N_INT-1:0] = int_flags;
            RA_INT_EN:   reg_rdata[N_INT-1:0] = int_en;
            RA_MASK:     reg_rdata[0]         = mask_q;
            default:     reg_rdata            = '0;
        endcase
    end

    intc_edge_sync #(.W(N_EXT)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .fn_sel    (pin_fn),
        .edge_rise (edge_rise),
        .edge_hit  (ext_hit)
    );

    intc_flag_bank #(.W(N_EXT)) u_ext_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_in   (ext_hit),
        .clr_we   (wr_ext_flag),
        .clr_data (reg_wdata[N_EXT-1:0]),
        .flags    (ext_flags)
    );

    intc_flag_bank #(.W(N_INT)) u_int_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_in   (int_strobe),
        .clr_we   (wr_int_flag),
        .clr_data (reg_wdata[N_INT-1:0]),
        .flags    (int_flags)
    );

    intc_arbiter #(.N_EXT(N_EXT), .N_INT(N_INT)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    ({int_flags & int_en, ext_flags & ext_en}),
        .mask    (mask_q),
        .ack     (irq_ack),
        .irq_req (irq_req),
        .irq_vec (irq_vec)
    );
endmodule

// File: rtl/intc_chk.sv
// intc_chk: protocol assertions on the request/acknowledge side of vect_intc.
module intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_ack,
    input logic       irq_req,
    input logic [4:0] irq_vec,
    input logic       mask_q
);
    // R9
    ack_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> mask_q);
    // R9
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_req);
    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> $stable(irq_vec));
    // R6
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> !irq_req);
    // R7
    legal_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= 5'd4 && irq_vec <= 5'd20 && irq_vec != 5'd9 && irq_vec != 5'd12));
    // R10
    rise_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(!mask_q));
endmodule

bind vect_intc intc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_ack (irq_ack),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .mask_q  (mask_q)
);

// File: tb/sim_vect_intc.sv
module sim_vect_intc;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] ext_pin;
    logic [9:0] int_strobe;
    logic       reg_we;
    logic [2:0] reg_addr;
    logic [9:0] reg_wdata;
    logic [9:0] reg_rdata;
    logic       irq_req;
    logic [4:0] irq_vec;
    logic       irq_ack;

    int n_chk = 0;
    int n_fail = 0;
    bit run_chk = 0;

    vect_intc u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_strobe(int_strobe),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int       vtab[15] = '{4, 5, 6, 7, 8, 10, 11, 13, 14, 15, 16, 17, 18, 19, 20};
    bit [4:0] pq[$];
    bit [4:0] m_eflag, m_een, m_fn, m_rise;
    bit [9:0] m_iflag, m_ien;
    bit       m_mask, m_req;
    int       m_vec;

    function automatic bit [9:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return {5'b0, m_eflag};
            3'd1: return {5'b0, m_een};
            3'd2: return {5'b0, m_fn};
            3'd3: return {5'b0, m_rise};
            3'd4: return m_iflag;
            3'd5: return m_ien;
            3'd6: return {9'b0, m_mask};
            default: return 10'b0;
        endcase
    endfunction

    always @(posedge clk) begin : mdl
        bit [4:0] older, newer, ev;
        int minv;
        bit pend;
        if (!rst_n) begin
            pq = '{5'b0, 5'b0, 5'b0};
            m_eflag = 0; m_een = 0; m_fn = 0; m_rise = 0;
            m_iflag = 0; m_ien = 0; m_mask = 1; m_req = 0; m_vec = 0;
        end else begin
            newer = pq[1];
            older = pq[2];
            for (int i = 0; i < 5; i++)
                ev[i] = m_fn[i] && (m_rise[i] ? (newer[i] && !older[i]) : (!newer[i] && older[i]));
            minv = 99;
            for (int s = 0; s < 15; s++) begin
                pend = (s < 5) ? (m_eflag[s] && m_een[s]) : (m_iflag[s-5] && m_ien[s-5]);
                if (pend && vtab[s] < minv) minv = vtab[s];
            end
            if (irq_ack || m_mask) m_req = 0;
            else if (!m_req && minv != 99) begin m_req = 1; m_vec = minv; end
            if (irq_ack) m_mask = 1;
            else if (reg_we && reg_addr == 3'd6) m_mask = reg_wdata[0];
            m_eflag = ((reg_we && reg_addr == 3'd0) ? (m_eflag & reg_wdata[4:0]) : m_eflag) | ev;
            m_iflag = ((reg_we && reg_addr == 3'd4) ? (m_iflag & reg_wdata) : m_iflag) | int_strobe;
            if (reg_we && reg_addr == 3'd1) m_een  = reg_wdata[4:0];
            if (reg_we && reg_addr == 3'd2) m_fn   = reg_wdata[4:0];
            if (reg_we && reg_addr == 3'd3) m_rise = reg_wdata[4:0];
            if (reg_we && reg_addr == 3'd5) m_ien  = reg_wdata;
            pq.push_front(ext_pin);
            void'(pq.pop_back());
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (run_chk && rst_n) begin
            chk("R10 req vs model", irq_req, m_req);
            if (m_req) chk("R7 vec vs model", irq_vec, m_vec);
            chk("R11 rdata vs model", reg_rdata, mread(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [9:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [9:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        #1;
    endtask

    task automatic ack_pulse();
        irq_ack = 1; cyc(1); irq_ack = 0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 0; ext_pin = 0; int_strobe = 0; reg_we = 0;
        reg_addr = 0; reg_wdata = 0; irq_ack = 0;
        cyc(3);
        chk("R1 req in reset", irq_req, 0);
        rst_n = 1; run_chk = 1;
        rd(3'd6, 10'h001, "R1 mask after reset");
        rd(3'd0, 10'h000, "R1 ext flags after reset");
        rd(3'd5, 10'h000, "R1 int enables after reset");

        // R2: function gate off blocks the edge
        wr(3'd3, 10'h001);
        wr(3'd2, 10'h000);
        ext_pin[0] = 1; cyc(5);
        rd(3'd0, 10'h000, "R2 gated pin");
        ext_pin[0] = 0; cyc(5);
        wr(3'd2, 10'h003);
        ext_pin[0] = 1; cyc(5);
        rd(3'd0, 10'h001, "R2 rising edge sets");
        ext_pin[1] = 1; cyc(5);
        rd(3'd0, 10'h001, "R2 rising ignored on falling select");
        ext_pin[1] = 0; cyc(5);
        rd(3'd0, 10'h003, "R2 falling edge sets");

        // R3: write-zero clears, write-one keeps
        wr(3'd0, 10'h01E);
        rd(3'd0, 10'h002, "R3 partial clear");
        wr(3'd0, 10'h000);
        rd(3'd0, 10'h000, "R3 full clear");

        // R4 / R5
        int_strobe = 10'h008; cyc(1); int_strobe = 0;
        rd(3'd4, 10'h008, "R4 strobe sets flag");
        wr(3'd6, 10'h000); cyc(3);
        chk("R5 disabled source no request", irq_req, 0);

        // R10 / R7
        wr(3'd5, 10'h008); cyc(3);
        chk("R10 request raised", irq_req, 1);
        chk("R7 internal 3 vector", irq_vec, 14);

        // R9: vector held while a better source arrives
        wr(3'd5, 10'h009);
        int_strobe = 10'h001; cyc(1); int_strobe = 0; cyc(3);
        chk("R9 request held", irq_req, 1);
        chk("R9 vector held", irq_vec, 14);
        ack_pulse();
        chk("R9 ack drops request", irq_req, 0);
        rd(3'd6, 10'h001, "R9 ack sets mask");
        cyc(3);
        chk("R6 masked pending", irq_req, 0);
        wr(3'd6, 10'h000); cyc(3);
        chk("R8 lowest internal wins", irq_vec, 10);

        // R8: external beats internal
        ack_pulse();
        wr(3'd1, 10'h002);
        ext_pin[1] = 1; cyc(5);
        ext_pin[1] = 0; cyc(5);
        rd(3'd0, 10'h002, "R2 second falling edge");
        chk("R6 mask holds off external", irq_req, 0);
        wr(3'd6, 10'h000); cyc(3);
        chk("R8 external over internal", irq_vec, 5);

        // R3: set wins over clear in the same cycle; R7 top vector
        ack_pulse();
        wr(3'd5, 10'h200);
        int_strobe = 10'h200; reg_we = 1; reg_addr = 3'd4; reg_wdata = 10'h000;
        cyc(1);
        int_strobe = 0; reg_we = 0;
        rd(3'd4, 10'h200, "R3 set beats clear");
        wr(3'd1, 10'h000);
        wr(3'd6, 10'h000); cyc(3);
        chk("R7 internal 9 vector", irq_vec, 20);

        // R8: IRQ0 beats IRQ1
        ack_pulse();
        wr(3'd1, 10'h003);
        ext_pin[0] = 0; cyc(5);
        ext_pin[0] = 1; cyc(5);
        rd(3'd0, 10'h003, "R2 pin0 and pin1 pending");
        wr(3'd6, 10'h000); cyc(3);
        chk("R8 pin0 over pin1", irq_vec, 4);

        // R11 readbacks
        rd(3'd2, 10'h003, "R11 pin function");
        rd(3'd3, 10'h001, "R11 edge select");
        rd(3'd1, 10'h003, "R11 ext enables");
        rd(3'd7, 10'h000, "R11 unused address");
        cyc(2);
        finish_up();
    end
endmodule